// File: doc/BRIEF.md
# Line Transmit Test Pattern Selector

This block decides which serial bit goes to a T1/E1 line transmitter on each transmit bit slot. A single clock enable (`tick`) marks the bit slots. On every slot the block chooses one of five sources and registers the chosen bit: the payload bit, a forced all-ones stream, an alternating one/zero stream, a pseudo-random test sequence, or a repeating loop-up code. A strobe marks each new output bit.

After reset the output carries all ones. Payload reaches the line only once `data_on` is driven high. When automatic all-ones is enabled, a flagged receive carrier loss also forces all ones for as long as it lasts. The pseudo-random source depends on the line mode. E1 uses a 15-stage generator. T1 uses a 20-stage generator with its zero runs capped, the quasi-random signal commonly used on T1 lines. The loop code is a programmable word of 1 to 16 bits, sent MSB first and repeated.

Top module: `tx_pattern_sel`

## Requirements
- R1: During reset and on the first cycle after it, `line_bit` is 1 and `line_vld` is 0.
- R2: `line_vld` is high exactly in the cycle after a cycle with `tick` high. `line_bit` changes only in that cycle and holds its value otherwise.
- R3: While `data_on` is 0, every output bit is 1, whatever the other controls and the payload are.
- R4: While `auto_ones` and `carrier_lost` are both 1, every output bit is 1. `carrier_lost` has no effect while `auto_ones` is 0.
- R5: When not forced to ones, `alt_on` sends bits that alternate 1,0,1,0. The first alternate bit after reset is 1, and the phase advances only on bits the pattern actually sends. This source takes priority over the PRBS and the loop code.
- R6: With `e1_mode`=1 the PRBS source follows x^15+x^14+1. All stages are seeded to 1. Each bit is stage15 XOR stage14, and that bit is shifted into stage 1.
- R7: With `e1_mode`=0 the PRBS source follows x^20+x^17+1, seeded to all ones, with each output bit being stage20 XOR stage17. After 14 consecutive output zeros, the next output bit is forced to 1, while the register still shifts in the unforced bit.
- R8: A rising edge of `prbs_on` reseeds the generator to all ones and clears the zero-run count. A bit slot in that same cycle is taken from the fresh seed. The generator advances only on slots where it is the selected source.
- R9: The loop source sends `loop_code[loop_len]` down to `loop_code[0]` and then repeats. `loop_len` holds the length minus 1. A rising edge of `loop_on` restarts at bit `loop_len`.
- R10: When not forced to ones and with `alt_on` at 0, the PRBS takes priority over the loop code, and the loop code takes priority over the payload.
- R11: With `data_on`=1, no carrier-loss forcing and no pattern enabled, `line_bit` equals the `pay_bit` presented with the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-slot clock enable |
| pay_bit | input | 1 | Payload bit for this slot |
| data_on | input | 1 | 1 lets payload and patterns through; 0 forces ones |
| auto_ones | input | 1 | Enables all-ones on carrier loss |
| carrier_lost | input | 1 | Receive carrier loss flag |
| alt_on | input | 1 | Alternating one/zero pattern enable |
| prbs_on | input | 1 | Pseudo-random pattern enable |
| loop_on | input | 1 | Loop-up code enable |
| e1_mode | input | 1 | 1 = E1 (15-stage PRBS), 0 = T1 (20-stage capped) |
| loop_code | input | CODE_W | Loop code word, MSB sent first |
| loop_len | input | $clog2(CODE_W) | Loop code length minus 1 |
| line_bit | output | 1 | Registered serial output bit |
| line_vld | output | 1 | Strobe, high for each new output bit |

## Verification
Two events can land in the same cycle. One is a rising edge of a pattern enable, which reseeds the PRBS or restarts the loop code. The other is the bit slot that must already use the fresh start state. The bench raises `prbs_on` and `loop_on` in the very cycle that carries a tick, with and without a higher-priority source active. It then judges the first bits against a reference generator that starts from the seed, or against the code MSB. The bench also holds carrier loss together with the alternate pattern, and checks that the forced ones do not consume any of the pattern's phase.

// File: rtl/txpat_pkg.sv
package txpat_pkg;

  typedef enum logic [2:0] {
    SRC_ONES = 3'd0,
    SRC_ALT  = 3'd1,
    SRC_PRBS = 3'd2,
    SRC_LOOP = 3'd3,
    SRC_DATA = 3'd4
  } src_t;

  // Fixed priority: forced ones, alternate, PRBS, loop code, payload.
  function automatic src_t pick_src(input logic force_ones, input logic alt,
                                    input logic prbs, input logic lcode);
    if (force_ones)  return SRC_ONES;
    else if (alt)    return SRC_ALT;
    else if (prbs)   return SRC_PRBS;
    else if (lcode)  return SRC_LOOP;
    else             return SRC_DATA;
  endfunction

endpackage

// File: rtl/txpat_prbs.sv
module txpat_prbs #(
  parameter int E1_N = 15,
  parameter int E1_T = 14,
  parameter int T1_N = 20,
  parameter int T1_T = 17,
  parameter int MAXZ = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic adv,
  input  logic e1,
  output logic pbit
);
  localparam int ZW = $clog2(MAXZ + 2);

  logic [T1_N-1:0] st, st_use;
  logic [ZW-1:0]   zcnt, zcnt_use;
  logic            arm_q, rise, raw;

  assign rise     = arm & ~arm_q;
  assign st_use   = rise ? '1 : st;
  assign zcnt_use = rise ? '0 : zcnt;
  assign raw      = e1 ? (st_use[E1_N-1] ^ st_use[E1_T-1])
                       : (st_use[T1_N-1] ^ st_use[T1_T-1]);
  assign pbit     = raw | (~e1 & (zcnt_use == ZW'(MAXZ)));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= '1;
      zcnt  <= '0;
      arm_q <= 1'b0;
    end else begin
      arm_q <= arm;
      if (adv) begin
        st <= {st_use[T1_N-2:0], raw};
        if (e1 || pbit) zcnt <= '0;
        else            zcnt <= zcnt_use + 1'b1;
      end else if (rise) begin
        st   <= '1;
        zcnt <= '0;
      end
    end
  end

  // R7: the zero run of the capped sequence never passes the limit
  a_r7_zero_cap: assert property (@(posedge clk) disable iff (rst)
    zcnt <= ZW'(MAXZ));

  // R8: a rising enable without a slot leaves the generator at its seed
  a_r8_reseed: assert property (@(posedge clk) disable iff (rst)
    (arm && !arm_q && !adv) |=> (st == '1 && zcnt == '0));

endmodule

// File: rtl/txpat_loop.sv
module txpat_loop #(
  parameter int CODE_W = 16,
  localparam int IW    = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              adv,
  input  logic [CODE_W-1:0] code,
  input  logic [IW-1:0]     len,
  output logic              lbit
);
  logic [IW-1:0] idx, idx_use;
  logic          arm_q, rise;

  assign rise    = arm & ~arm_q;
  assign idx_use = rise ? len : idx;
  assign lbit    = code[idx_use];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      arm_q <= 1'b0;
    end else begin
      arm_q <= arm;
      if (adv)       idx <= (idx_use == '0) ? len : idx_use - 1'b1;
      else if (rise) idx <= len;
    end
  end

  // R9: after sending bit 0 the word restarts at its MSB
  a_r9_wrap: assert property (@(posedge clk) disable iff (rst)
    (adv && idx_use == '0) |=> (idx == $past(len)));

endmodule

// File: rtl/tx_pattern_sel.sv
module tx_pattern_sel
  import txpat_pkg::*;
#(
  parameter int CODE_W = 16,
  parameter int E1_N   = 15,
  parameter int E1_T   = 14,
  parameter int T1_N   = 20,
  parameter int T1_T   = 17,
  parameter int MAXZ   = 14,
  localparam int IW    = $clog2(CODE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              pay_bit,
  input  logic              data_on,
  input  logic              auto_ones,
  input  logic              carrier_lost,
  input  logic              alt_on,
  input  logic              prbs_on,
  input  logic              loop_on,
  input  logic              e1_mode,
  input  logic [CODE_W-1:0] loop_code,
  input  logic [IW-1:0]     loop_len,
  output logic              line_bit,
  output logic              line_vld
);
  src_t src;
  logic force_ones, alt_ph, pbit, lbit, nxt;
  logic adv_prbs, adv_loop;

  assign force_ones = ~data_on | (auto_ones & carrier_lost);
  assign src        = pick_src(force_ones, alt_on, prbs_on, loop_on);
  assign adv_prbs   = tick & (src == SRC_PRBS);
  assign adv_loop   = tick & (src == SRC_LOOP);

  txpat_prbs #(.E1_N(E1_N), .E1_T(E1_T), .T1_N(T1_N), .T1_T(T1_T), .MAXZ(MAXZ))
    u_prbs (.clk(clk), .rst(rst), .arm(prbs_on), .adv(adv_prbs), .e1(e1_mode),
            .pbit(pbit));

  txpat_loop #(.CODE_W(CODE_W))
    u_loop (.clk(clk), .rst(rst), .arm(loop_on), .adv(adv_loop), .code(loop_code),
            .len(loop_len), .lbit(lbit));

  always_comb begin
    unique case (src)
      SRC_ONES: nxt = 1'b1;
      SRC_ALT:  nxt = alt_ph;
      SRC_PRBS: nxt = pbit;
      SRC_LOOP: nxt = lbit;
      default:  nxt = pay_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit <= 1'b1;
      line_vld <= 1'b0;
      alt_ph   <= 1'b1;
    end else begin
      line_vld <= tick;
      if (tick) line_bit <= nxt;
      if (tick && src == SRC_ALT) alt_ph <= ~alt_ph;
    end
  end

  // R1: reset values are visible on the first cycle after reset
  a_r1_reset_ones: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_bit && !line_vld));

  // R2: strobe follows the slot enable by one cycle
  a_r2_strobe: assert property (@(posedge clk) disable iff (rst)
    tick |=> line_vld);

  // R2: without a slot the line bit holds
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(line_bit) && !line_vld));

  // R3: data disabled means ones on the line
  a_r3_disabled_ones: assert property (@(posedge clk) disable iff (rst)
    (tick && !data_on) |=> line_bit);

  // R4: automatic ones on carrier loss
  a_r4_auto_ones: assert property (@(posedge clk) disable iff (rst)
    (tick && auto_ones && carrier_lost) |=> line_bit);

endmodule

// File: tb/test_tx_pattern_sel.sv
module test_tx_pattern_sel;
  localparam int CODE_W = 16;
  localparam int IW     = $clog2(CODE_W);

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, pay_bit = 1'b0;
  logic data_on = 1'b0, auto_ones = 1'b0, carrier_lost = 1'b0;
  logic alt_on = 1'b0, prbs_on = 1'b0, loop_on = 1'b0, e1_mode = 1'b1;
  logic [CODE_W-1:0] loop_code = '0;
  logic [IW-1:0]     loop_len = '0;
  logic line_bit, line_vld;

  int checks = 0, fails = 0;
  logic [19:0] m;
  int mz, zrun;

  always #5 clk = ~clk;

  tx_pattern_sel #(.CODE_W(CODE_W)) i_tx_pattern_sel (
    .clk(clk), .rst(rst), .tick(tick), .pay_bit(pay_bit), .data_on(data_on),
    .auto_ones(auto_ones), .carrier_lost(carrier_lost), .alt_on(alt_on),
    .prbs_on(prbs_on), .loop_on(loop_on), .e1_mode(e1_mode),
    .loop_code(loop_code), .loop_len(loop_len),
    .line_bit(line_bit), .line_vld(line_vld));

  // fields: data_on auto lost alt prbs loop pay expected
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    8'b0000_0011, // R3 payload 1, disabled
    8'b0000_0001, // R3 payload 0, disabled -> 1
    8'b0001_1101, // R3 patterns on, disabled
    8'b1000_0000, // R11 payload 0
    8'b1000_0011, // R11 payload 1
    8'b1110_0001, // R4 forced
    8'b1111_1101, // R4 forced over all patterns
    8'b1010_0000, // R4 loss ignored without auto
    8'b1100_0000, // R4 auto without loss
    8'b1010_0011  // R4 loss ignored, payload 1
  };

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send_bit();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic e1_step();
    logic fb;
    fb = m[14] ^ m[13];
    m = {m[18:0], fb};
    return fb;
  endfunction

  function automatic logic t1_step();
    logic raw, o;
    raw = m[19] ^ m[16];
    m = {m[18:0], raw};
    o = (!raw && mz == 14) ? 1'b1 : raw;
    mz = o ? 0 : mz + 1;
    return o;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic exp_alt;
    logic [4:0] pat5;
    @(negedge clk); @(negedge clk);
    check("R1 reset bit", line_bit, 1'b1);
    check("R1 reset vld", line_vld, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset bit", line_bit, 1'b1);
    check("R1 after reset vld", line_vld, 1'b0);
    pay_bit = 1'b0;
    send_bit();
    check("R1 first slot ones", line_bit, 1'b1);
    check("R2 strobe", line_vld, 1'b1);

    for (int i = 0; i < NV; i++) begin
      {data_on, auto_ones, carrier_lost, alt_on, prbs_on, loop_on, pay_bit} = VEC[i][7:1];
      send_bit();
      check($sformatf("R3/R4/R11 vector %0d", i), line_bit, VEC[i][0]);
    end
    {alt_on, prbs_on, loop_on, auto_ones, carrier_lost} = '0;

    // R2: idle cycle holds bit, no strobe
    data_on = 1'b1; pay_bit = 1'b0; send_bit();
    pay_bit = 1'b1;
    @(negedge clk);
    check("R2 no strobe idle", line_vld, 1'b0);
    check("R2 hold idle", line_bit, 1'b0);

    // R5: alternate over PRBS and loop; forcing does not consume phase
    exp_alt = 1'b1;
    alt_on = 1'b1; prbs_on = 1'b1; loop_on = 1'b1; e1_mode = 1'b1;
    loop_code = 16'h0016; loop_len = 4'd4;
    for (int i = 0; i < 6; i++) begin
      if (i == 3) begin
        auto_ones = 1'b1; carrier_lost = 1'b1;
        send_bit();
        check("R4 forced during alt", line_bit, 1'b1);
        auto_ones = 1'b0; carrier_lost = 1'b0;
      end
      send_bit();
      check($sformatf("R5 alt bit %0d", i), line_bit, exp_alt);
      exp_alt = ~exp_alt;
    end

    // R6/R10: E1 PRBS over loop code, from seed
    alt_on = 1'b0; m = '1;
    for (int i = 0; i < 200; i++) begin
      send_bit();
      check($sformatf("R6 R10 e1 bit %0d", i), line_bit, e1_step());
    end

    // R8: reseed on rising enable in a slot cycle
    prbs_on = 1'b0; @(negedge clk);
    prbs_on = 1'b1; m = '1;
    for (int i = 0; i < 40; i++) begin
      send_bit();
      check($sformatf("R8 reseed bit %0d", i), line_bit, e1_step());
    end

    // R7: T1 capped sequence
    prbs_on = 1'b0; e1_mode = 1'b0; @(negedge clk);
    prbs_on = 1'b1; m = '1; mz = 0; zrun = 0;
    for (int i = 0; i < 3000; i++) begin
      logic e;
      e = t1_step();
      send_bit();
      check($sformatf("R7 t1 bit %0d", i), line_bit, e);
      zrun = line_bit ? 0 : zrun + 1;
      if (zrun > 14) check("R7 zero run", 1'b1, 1'b0);
    end

    // R9/R10: loop code over payload, 5-bit word 10110
    prbs_on = 1'b0; loop_on = 1'b0; pay_bit = 1'b0; @(negedge clk);
    loop_on = 1'b1; pat5 = 5'b10110;
    for (int i = 0; i < 15; i++) begin
      send_bit();
      check($sformatf("R9 R10 loop5 bit %0d", i), line_bit, pat5[4 - (i % 5)]);
    end

    // R9: single-bit word
    loop_on = 1'b0; loop_code = 16'hFFFE; loop_len = 4'd0; @(negedge clk);
    loop_on = 1'b1; pay_bit = 1'b1;
    for (int i = 0; i < 4; i++) begin
      send_bit();
      check($sformatf("R9 loop1 bit %0d", i), line_bit, 1'b0);
    end

    // R9: full 16-bit word, MSB first
    loop_on = 1'b0; loop_code = 16'hA5C3; loop_len = 4'd15; @(negedge clk);
    loop_on = 1'b1;
    for (int i = 0; i < 32; i++) begin
      send_bit();
      check($sformatf("R9 loop16 bit %0d", i), line_bit, loop_code[15 - (i % 16)]);
    end

    // R11: back to payload
    loop_on = 1'b0; pay_bit = 1'b1; send_bit();
    check("R11 payload after loop", line_bit, 1'b1);
    pay_bit = 1'b0; send_bit();
    check("R11 payload 0", line_bit, 1'b0);

    // R3: disable again forces ones
    data_on = 1'b0; send_bit();
    check("R3 disable forces ones", line_bit, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule